// File: doc/BRIEF.md
# Multi-Lane Alphanumeric Key Counter

This block feeds candidate keys to a bank of parallel search engines. Every key is built from eight characters, each one a 7-bit ASCII code drawn from the 62 letters and digits, so a full key is 56 bits wide. One shared counter supplies the seven low characters. Each of six lanes owns a disjoint slice of the alphabet for its leading character. Joining the shared low part to each lane's own leading character gives six distinct keys on every accepted beat.

The characters count in a fixed order: lower-case letters first, then upper-case letters, then decimal digits. A character that steps past the last digit returns to 'a' and carries into the next character up. When the shared counter wraps from all '9' back to all 'a', every lane moves its leading character one place forward inside its own slice. Lanes with shorter slices run out first and drop their valid bit. The longer lanes keep going. After the last key of the longest lane has been taken, a finished flag rises and stays high.

The key outputs behave as a stream source with one ready input shared by all lanes. A beat is accepted on a rising clock edge where `out_ready` is high and `done` is low. Only an accepted beat moves the counter. While `out_ready` is low, every key and every valid bit holds its value. A downstream consumer may hold `out_ready` low for any number of cycles. Valid does not wait for ready.

Top module: `lane_key_counter`

## Requirements
- R1: After reset the shared low characters are all 'a', every lane's valid bit is high, `done` is low, and the lanes' leading characters are 'a', 'l', 'w', 'G', 'Q' and '0' for lanes 0 to 5.
- R2: A character's index i (0 to 61) maps to ASCII as follows: 'a'+i for i<26, 'A'+(i-26) for i<52, and '0'+(i-52) otherwise.
- R3: Each accepted beat adds one to the shared low counter. The lowest character sits in key bits 6:0, and higher characters sit in successively higher 7-bit fields. A character steps through the R2 order, so 'z' goes to 'A' and 'Z' goes to '0'. A character going from '9' to 'a' carries one into the next character up.
- R4: All valid lanes present the same low characters in the same cycle.
- R5: The leading character sits in the top 7 bits of each key. Lane k's key occupies bits [k*KEY_W +: KEY_W] of `lane_key`. Lanes 0 and 1 own 11 leading characters each (a..k and l..v). Lanes 2 to 5 own 10 each (w..F, G..P, Q..Z and 0..9).
- R6: When an accepted beat wraps the shared counter from all '9' to all 'a', every lane's leading character advances one place inside its slice.
- R7: While `out_ready` is low, all keys, valid bits and `done` keep their values.
- R8: A lane whose slice is exhausted drops its valid bit, and its key reads zero. Lanes 0 and 1 remain valid for one more sweep of the shared counter. A valid bit never returns high before reset.
- R9: `done` rises in the cycle after the final beat of lane 0 is accepted. From then on every valid bit is low, and `done` stays high until reset whatever `out_ready` does.
- R10: A full scan accepts exactly 11 * 62^LOW_DIGITS beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; releasing it starts a new scan |
| out_ready | input | 1 | Consumer accepts the current beat of all lanes |
| lane_key | output | LANES*KEY_W | Packed keys, lane k at bits [k*KEY_W +: KEY_W] |
| lane_valid | output | LANES | Per-lane key valid |
| done | output | 1 | Scan complete, sticky until reset |

## Verification
The assertions put no limit on `out_ready`; any ready pattern is legal. They do assume reset is held low over at least one rising edge before the first beat. The check on lane 0's leading character assumes lane 0's slice lies within the lower-case letters, which holds whenever there are at least three lanes. The bench shortens the shared counter to two characters so that a complete scan fits in the run. It gates ready with two interleaved irregular stall patterns, which cover both long and short back-pressure across every wrap and lane drop-out.

// File: rtl/kc_pkg.sv
package kc_pkg;
  localparam int ALPHA = 62;
  localparam int CW    = 7;
  localparam int IW    = 6;

  function automatic logic [CW-1:0] idx_to_char(input logic [IW-1:0] i);
    logic [CW-1:0] e;
    e = {1'b0, i};
    if (i < 6'd26)      return 7'h61 + e;
    else if (i < 6'd52) return 7'h41 + e - 7'd26;
    else                return 7'h30 + e - 7'd52;
  endfunction

  function automatic int lane_size(input int lanes, input int lane);
    return ALPHA / lanes + ((lane < ALPHA % lanes) ? 1 : 0);
  endfunction

  function automatic int lane_start(input int lanes, input int lane);
    int s;
    s = 0;
    for (int j = 0; j < lane; j++) s += lane_size(lanes, j);
    return s;
  endfunction
endpackage

// File: rtl/kc_digit.sv
module kc_digit
  import kc_pkg::*;
(
  input  logic [IW-1:0] idx_i,
  input  logic          cin,
  output logic [IW-1:0] idx_o,
  output logic          cout
);
  localparam logic [IW-1:0] TOP = IW'(ALPHA - 1);

  always_comb begin
    cout = cin && (idx_i == TOP);
    if (!cin)              idx_o = idx_i;
    else if (idx_i == TOP) idx_o = '0;
    else                   idx_o = idx_i + 1'b1;
  end
endmodule

// File: rtl/kc_common.sv
module kc_common
  import kc_pkg::*;
#(
  parameter int DIGITS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  output logic [DIGITS*IW-1:0] idx,
  output logic                 wrap
);
  logic [DIGITS*IW-1:0] cur;
  logic [DIGITS*IW-1:0] nxt;
  logic [DIGITS:0]      carry;

  assign carry[0] = 1'b1;

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    kc_digit u_dig (
      .idx_i (cur[d*IW +: IW]),
      .cin   (carry[d]),
      .idx_o (nxt[d*IW +: IW]),
      .cout  (carry[d+1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= '0;
    else if (step) cur <= nxt;
  end

  assign idx  = cur;
  assign wrap = carry[DIGITS];
endmodule

// File: rtl/kc_lead.sv
module kc_lead #(
  parameter int MAXSZ = 11,
  parameter int OFF_W = $clog2(MAXSZ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             wrap,
  output logic [OFF_W-1:0] off,
  output logic             done
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(MAXSZ - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off  <= '0;
      done <= 1'b0;
    end else if (step && wrap) begin
      if (off == LAST) done <= 1'b1;
      else             off  <= off + 1'b1;
    end
  end
endmodule

// File: rtl/kc_lane.sv
module kc_lane
  import kc_pkg::*;
#(
  parameter int START  = 0,
  parameter int SIZE   = 11,
  parameter int DIGITS = 7,
  parameter int OFF_W  = 4,
  localparam int KEY_W = CW * (DIGITS + 1)
) (
  input  logic [OFF_W-1:0]     off,
  input  logic                 done,
  input  logic [DIGITS*IW-1:0] low,
  output logic [KEY_W-1:0]     key,
  output logic                 valid
);
  logic [IW-1:0] lead;

  assign valid = !done && (off < OFF_W'(SIZE));
  assign lead  = IW'(START) + IW'(off);

  always_comb begin
    key = '0;
    if (valid) begin
      for (int k = 0; k < DIGITS; k++)
        key[k*CW +: CW] = idx_to_char(low[k*IW +: IW]);
      key[DIGITS*CW +: CW] = idx_to_char(lead);
    end
  end
endmodule

// File: rtl/lane_key_counter.sv
module lane_key_counter
  import kc_pkg::*;
#(
  parameter int LANES      = 6,
  parameter int LOW_DIGITS = 7,
  localparam int KEY_W = CW * (LOW_DIGITS + 1),
  localparam int MAXSZ = ALPHA / LANES + ((ALPHA % LANES != 0) ? 1 : 0),
  localparam int OFF_W = $clog2(MAXSZ + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   out_ready,
  output logic [LANES*KEY_W-1:0] lane_key,
  output logic [LANES-1:0]       lane_valid,
  output logic                   done
);
  logic                     step;
  logic                     wrap;
  logic [LOW_DIGITS*IW-1:0] low;
  logic [OFF_W-1:0]         off;

  assign step = out_ready && !done;

  kc_common #(.DIGITS(LOW_DIGITS)) u_common (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .idx   (low),
    .wrap  (wrap)
  );

  kc_lead #(.MAXSZ(MAXSZ), .OFF_W(OFF_W)) u_lead (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .wrap  (wrap),
    .off   (off),
    .done  (done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    kc_lane #(
      .START  (lane_start(LANES, g)),
      .SIZE   (lane_size(LANES, g)),
      .DIGITS (LOW_DIGITS),
      .OFF_W  (OFF_W)
    ) u_lane (
      .off   (off),
      .done  (done),
      .low   (low),
      .key   (lane_key[g*KEY_W +: KEY_W]),
      .valid (lane_valid[g])
    );
  end
endmodule

// File: rtl/kc_checker.sv
module kc_checker #(
  parameter int LANES      = 6,
  parameter int LOW_DIGITS = 7
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 out_ready,
  input logic [LANES*7*(LOW_DIGITS+1)-1:0]    lane_key,
  input logic [LANES-1:0]                     lane_valid,
  input logic                                 done
);
  localparam int KEY_W = 7 * (LOW_DIGITS + 1);
  localparam int LW    = 7 * LOW_DIGITS;
  localparam int SZ0   = 62 / LANES + ((62 % LANES != 0) ? 1 : 0);
  localparam logic [6:0] L0_LAST = 7'(8'h61 + SZ0 - 1);

  logic [6:0] lead0;
  assign lead0 = lane_key[KEY_W-1 -: 7];

  // R7: stalled beat freezes every output
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && !done) |=> ($stable(lane_key) && $stable(lane_valid) && $stable(done)));

  // R3: an accepted beat always moves the lowest character of lane 0
  a_r3_low_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !done) |=> !$stable(lane_key[6:0]));

  // R4: shared low part is identical in the first and last lane
  a_r4_shared_low: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid[0] && lane_valid[LANES-1]) |->
      (lane_key[LW-1:0] == lane_key[(LANES-1)*KEY_W +: LW]));

  // R5: lane 0's leading character stays inside its slice
  a_r5_lane0_lead: assert property (@(posedge clk) disable iff (!rst_n)
    lane_valid[0] |-> (lead0 >= 7'h61 && lead0 <= L0_LAST));

  // R8: a dropped valid bit never returns
  a_r8_valid_no_return: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lane_valid & ~$past(lane_valid)) == '0));

  // R9: finished flag is sticky
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R9: nothing valid once finished
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lane_valid == '0));
endmodule

bind lane_key_counter kc_checker #(.LANES(LANES), .LOW_DIGITS(LOW_DIGITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .out_ready  (out_ready),
  .lane_key   (lane_key),
  .lane_valid (lane_valid),
  .done       (done)
);

// File: tb/sim_lane_key_counter.sv
module sim_lane_key_counter;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 6;
  localparam int LOW   = 2;
  localparam int KW    = 7 * (LOW + 1);
  localparam longint CMAX = 62 * 62;
  localparam int LIMIT = 120000;

  logic clk = 1'b0;
  logic rst_n;
  logic out_ready;
  logic [LANES*KW-1:0] lane_key;
  logic [LANES-1:0] lane_valid;
  logic done;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_key_counter #(.LANES(LANES), .LOW_DIGITS(LOW)) u0 (
    .clk(clk), .rst_n(rst_n), .out_ready(out_ready),
    .lane_key(lane_key), .lane_valid(lane_valid), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;
  int starts[LANES] = '{0, 11, 22, 32, 42, 52};
  int sizes[LANES]  = '{11, 11, 10, 10, 10, 10};

  longint mc;
  int mo;
  bit mdone;
  longint beats;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] enc(input int i);
    if (i < 26) return 7'(8'h61 + i);
    if (i < 52) return 7'(8'h41 + i - 26);
    return 7'(8'h30 + i - 52);
  endfunction

  function automatic bit lvalid(input int l);
    return !mdone && (mo < sizes[l]);
  endfunction

  function automatic logic [KW-1:0] exp_key(input int l);
    logic [KW-1:0] k;
    longint c;
    k = '0;
    if (lvalid(l)) begin
      c = mc;
      for (int d = 0; d < LOW; d++) begin
        k[d*7 +: 7] = enc(int'(c % 62));
        c = c / 62;
      end
      k[LOW*7 +: 7] = enc(starts[l] + mo);
    end
    return k;
  endfunction

  task automatic compare_all(input string tag);
    logic [LANES-1:0] ev;
    for (int l = 0; l < LANES; l++) begin
      ev[l] = lvalid(l);
      chk(lane_key[l*KW +: KW] == exp_key(l), tag,
          longint'(lane_key[l*KW +: KW]), longint'(exp_key(l)));
    end
    chk(lane_valid == ev, {tag, " R8 valid"}, longint'(lane_valid), longint'(ev));
    chk(done == mdone, {tag, " R9 done"}, longint'(done), longint'(mdone));
  endtask

  task automatic model_reset();
    mc = 0; mo = 0; mdone = 0; beats = 0;
  endtask

  task automatic model_step();
    beats++;
    if (mc == CMAX - 1) begin
      mc = 0;
      if (mo == sizes[0] - 1) mdone = 1;
      else mo++;
    end else mc++;
  endtask

  initial begin
    int cyc;
    bit timed_out;
    bit prev_stall;
    logic [LANES*KW-1:0] prev_key;
    bit seen_upper, seen_digit, seen_drop;

    rst_n = 1'b0;
    out_ready = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state, leading characters a l w G Q 0
    chk(lane_key[0*KW + LOW*7 +: 7] == 7'h61, "R1 lane0 lead", longint'(lane_key[LOW*7 +: 7]), 64'h61);
    chk(lane_key[1*KW + LOW*7 +: 7] == 7'h6c, "R1 lane1 lead", longint'(lane_key[KW + LOW*7 +: 7]), 64'h6c);
    chk(lane_key[2*KW + LOW*7 +: 7] == 7'h77, "R1 lane2 lead", longint'(lane_key[2*KW + LOW*7 +: 7]), 64'h77);
    chk(lane_key[3*KW + LOW*7 +: 7] == 7'h47, "R1 lane3 lead", longint'(lane_key[3*KW + LOW*7 +: 7]), 64'h47);
    chk(lane_key[4*KW + LOW*7 +: 7] == 7'h51, "R1 lane4 lead", longint'(lane_key[4*KW + LOW*7 +: 7]), 64'h51);
    chk(lane_key[5*KW + LOW*7 +: 7] == 7'h30, "R1 lane5 lead", longint'(lane_key[5*KW + LOW*7 +: 7]), 64'h30);
    chk(lane_key[LOW*7-1:0] == {LOW{7'h61}}, "R1 low all a", longint'(lane_key[LOW*7-1:0]), 64'h30e1);
    chk(lane_valid == '1 && !done, "R1 valid/done", longint'({lane_valid, done}), 64'h7e);

    cyc = 0; timed_out = 0; prev_stall = 0; prev_key = lane_key;
    seen_upper = 0; seen_digit = 0; seen_drop = 0;
    while (!mdone) begin
      compare_all("R3 R4 R5 R6 key");
      if (prev_stall)
        chk(lane_key == prev_key, "R7 hold", longint'(lane_key[KW-1:0]), longint'(prev_key[KW-1:0]));
      if (!seen_upper && mc == 26) begin
        seen_upper = 1;
        chk(lane_key[6:0] == 7'h41, "R2 z->A", longint'(lane_key[6:0]), 64'h41);
      end
      if (!seen_digit && mc == 52) begin
        seen_digit = 1;
        chk(lane_key[6:0] == 7'h30, "R2 Z->0", longint'(lane_key[6:0]), 64'h30);
      end
      if (!seen_drop && mo == 10) begin
        seen_drop = 1;
        chk(lane_valid == 6'b000011, "R8 short lanes drop", longint'(lane_valid), 64'h3);
        chk(lane_key[5*KW +: KW] == '0, "R8 dropped key zero", longint'(lane_key[5*KW +: KW]), 0);
      end
      out_ready = !((cyc % 7) == 3 || (cyc % 13) == 5 || (cyc % 101) < 4);
      prev_stall = !out_ready;
      prev_key = lane_key;
      if (out_ready) model_step();
      @(negedge clk);
      #1;
      cyc++;
      if (cyc > LIMIT) begin timed_out = 1; break; end
    end
    if (timed_out) chk(1'b0, "watchdog", cyc, LIMIT);

    compare_all("R9 final");
    chk(beats == 11 * CMAX, "R10 beat count", beats, 11 * CMAX);
    for (int i = 0; i < 20; i++) begin
      out_ready = i[0];
      @(negedge clk);
      #1;
      chk(done && lane_valid == '0, "R9 sticky", longint'({lane_valid, done}), 1);
    end

    rst_n = 1'b0;
    #1;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare_all("R1 re-reset");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule